// File: doc/BRIEF.md
# Binary SIMD Pixel Processing Element

This block is the processor for one pixel of a binary image array. Every element of the array receives the same instruction word in the same cycle and executes it on its own data. The element keeps its working images as a small bank of 1-bit registers. Each cycle it forms two operands, combines them with a one-bit Boolean function, and writes the result back into the bank. Operand B always comes from the bank. Operand A comes either from the bank or from one of the four adjacent elements.

The element also drives one bank bit, chosen by its own address field, to its four neighbours. A neighbour can therefore read any of this element's registers while this element computes on other ones. A global enable lets the controller freeze every element at once. The instruction fields drive the element's multiplexers directly, with no decoding stage.

Top module: `pe_binary_cell`

## Requirements
- R1: A synchronous active-high reset clears every bank register to 0.
- R2: With S address bits, the instruction word is 4S+3 bits wide. From the MSB down it holds: op (2 bits), a_from (1 bit), a_addr (S bits), b_addr (S bits), r_addr (S bits) and out_addr (S bits). For S=3 this is op[14:13], a_from[12], a_addr[11:9], b_addr[8:6], r_addr[5:3] and out_addr[2:0].
- R3: The op field selects the result function: 00 passes A, 01 inverts A, 10 gives A AND B, 11 gives A OR B. Pass and invert do not depend on B.
- R4: When a_from is 1, operand A is a neighbour input selected by a_addr[1:0]: 00 north, 01 east, 10 west, 11 south. The upper a_addr bits are ignored. When a_from is 0, A is bank register a_addr.
- R5: Operand B is always bank register b_addr.
- R6: With proc_en high, the result is written at the clock edge into register r_addr only, and all other registers keep their values.
- R7: With proc_en low, no bank register changes, whatever the instruction.
- R8: A register that is both an operand and the destination in one instruction is read with its value from before the edge.
- R9: nbr_out always equals bank register out_addr, combinationally, regardless of the other fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_en | input | 1 | Global write enable for the bank |
| instr_word | input | 4S+3 | Broadcast instruction (15 bits at S=3) |
| nbr_n | input | 1 | Bit from the north neighbour |
| nbr_e | input | 1 | Bit from the east neighbour |
| nbr_w | input | 1 | Bit from the west neighbour |
| nbr_s | input | 1 | Bit from the south neighbour |
| nbr_out | output | 1 | Selected bank bit driven to the neighbours |

## Verification
The bench uses the default S=3, which gives an 8-register bank and a 15-bit instruction. At this size, every combination of op, a_from, a_addr, b_addr and r_addr can be applied: 4096 instructions. This covers every aliasing case between operand and destination addresses, and every neighbour selection including the ignored upper a_addr bit. After each instruction, the bench sweeps out_addr over all eight registers and compares the whole bank with an arithmetic model. This also exposes a write to the wrong register or a write while the enable is low.

// File: rtl/pe_pkg.sv
package pe_pkg;

    typedef enum logic [1:0] {
        OP_PASS = 2'b00,
        OP_INV  = 2'b01,
        OP_AND  = 2'b10,
        OP_OR   = 2'b11
    } pe_op_e;

    typedef enum logic [1:0] {
        DIR_N = 2'b00,
        DIR_E = 2'b01,
        DIR_W = 2'b10,
        DIR_S = 2'b11
    } pe_dir_e;

    localparam int NUM_DIRS = 4;

    function automatic logic pe_eval(input pe_op_e op, input logic a, input logic b);
        logic r;
        unique case (op)
            OP_PASS: r = a;
            OP_INV:  r = ~a;
            OP_AND:  r = a & b;
            default: r = a | b;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pe_regbank.sv
module pe_regbank #(
    parameter int S   = 3,
    parameter int NRD = 3,
    localparam int N  = 1 << S
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [S-1:0] wr_addr,
    input  logic         wr_data,
    input  logic [S-1:0] rd_addr [NRD],
    output logic         rd_data [NRD],
    output logic [N-1:0] bank_q
);

    logic [N-1:0] wr_sel;

    always_comb begin
        wr_sel          = '0;
        wr_sel[wr_addr] = wr_en;
    end

    for (genvar i = 0; i < N; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q[i] <= 1'b0;
            end else if (wr_sel[i]) begin
                bank_q[i] <= wr_data;
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = bank_q[rd_addr[p]];
    end

endmodule

// File: rtl/pe_nbr_route.sv
module pe_nbr_route
    import pe_pkg::*;
(
    input  logic [NUM_DIRS-1:0] nbr_vec,
    input  pe_dir_e             sel,
    output logic                nbr_bit
);

    always_comb begin
        unique case (sel)
            DIR_N:   nbr_bit = nbr_vec[DIR_N];
            DIR_E:   nbr_bit = nbr_vec[DIR_E];
            DIR_W:   nbr_bit = nbr_vec[DIR_W];
            default: nbr_bit = nbr_vec[DIR_S];
        endcase
    end

endmodule

// File: rtl/pe_logic.sv
module pe_logic
    import pe_pkg::*;
(
    input  pe_op_e op,
    input  logic   opa,
    input  logic   opb,
    output logic   res
);

    assign res = pe_eval(op, opa, opb);

endmodule

// File: rtl/pe_binary_cell.sv
module pe_binary_cell
    import pe_pkg::*;
#(
    parameter int S = 3,
    localparam int N = 1 << S,
    localparam int INSTR_W = 4 * S + 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               proc_en,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic               nbr_n,
    input  logic               nbr_e,
    input  logic               nbr_w,
    input  logic               nbr_s,
    output logic               nbr_out
);

    localparam int PORT_A   = 0;
    localparam int PORT_B   = 1;
    localparam int PORT_OUT = 2;
    localparam int NRD      = 3;

    typedef struct packed {
        pe_op_e       op;
        logic         a_from;
        logic [S-1:0] a_addr;
        logic [S-1:0] b_addr;
        logic [S-1:0] r_addr;
        logic [S-1:0] out_addr;
    } instr_t;

    instr_t              ins;
    logic [S-1:0]        rd_addr [NRD];
    logic                rd_data [NRD];
    logic [N-1:0]        bank_q;
    logic [NUM_DIRS-1:0] nbr_vec;
    logic                nbr_bit;
    logic                opa;
    logic                res;

    assign ins = instr_t'(instr_word);

    assign rd_addr[PORT_A]   = ins.a_addr;
    assign rd_addr[PORT_B]   = ins.b_addr;
    assign rd_addr[PORT_OUT] = ins.out_addr;

    always_comb begin
        nbr_vec        = '0;
        nbr_vec[DIR_N] = nbr_n;
        nbr_vec[DIR_E] = nbr_e;
        nbr_vec[DIR_W] = nbr_w;
        nbr_vec[DIR_S] = nbr_s;
    end

    pe_regbank #(.S(S), .NRD(NRD)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (proc_en),
        .wr_addr (ins.r_addr),
        .wr_data (res),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .bank_q  (bank_q)
    );

    pe_nbr_route u_route (
        .nbr_vec (nbr_vec),
        .sel     (pe_dir_e'(ins.a_addr[1:0])),
        .nbr_bit (nbr_bit)
    );

    assign opa = ins.a_from ? nbr_bit : rd_data[PORT_A];

    pe_logic u_logic (
        .op  (ins.op),
        .opa (opa),
        .opb (rd_data[PORT_B]),
        .res (res)
    );

    assign nbr_out = rd_data[PORT_OUT];

endmodule

// File: rtl/pe_binary_cell_chk.sv
module pe_binary_cell_chk
    import pe_pkg::*;
#(
    parameter int S = 3,
    localparam int N = 1 << S,
    localparam int INSTR_W = 4 * S + 3
) (
    input logic               clk,
    input logic               rst,
    input logic               proc_en,
    input logic [INSTR_W-1:0] instr_word,
    input logic               nbr_n,
    input logic               nbr_out,
    input logic [N-1:0]       bank_q
);

    logic [1:0]   c_op;
    logic         c_from;
    logic [S-1:0] c_a;
    logic [S-1:0] c_r;
    logic [S-1:0] c_out;
    logic [N-1:0] keep_mask;

    assign c_op      = instr_word[INSTR_W-1 -: 2];
    assign c_from    = instr_word[4*S];
    assign c_a       = instr_word[4*S-1 -: S];
    assign c_r       = instr_word[2*S-1 -: S];
    assign c_out     = instr_word[S-1:0];
    assign keep_mask = ~(N'(1) << c_r);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (bank_q == '0)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !proc_en |=> (bank_q == $past(bank_q))); // R7

    AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (rst)
        proc_en |=> (((bank_q ^ $past(bank_q)) & $past(keep_mask)) == '0)); // R6

    AST_OUT_SELECT: assert property (@(posedge clk) disable iff (rst)
        nbr_out == bank_q[c_out]); // R9

    AST_COPY_OLD: assert property (@(posedge clk) disable iff (rst)
        (proc_en && c_op == 2'b00 && !c_from) |=> (bank_q[$past(c_r)] == $past(bank_q[c_a]))); // R8

    AST_NBR_INV: assert property (@(posedge clk) disable iff (rst)
        (proc_en && c_op == 2'b01 && c_from && c_a[1:0] == 2'b00) |=> (bank_q[$past(c_r)] == !$past(nbr_n))); // R4

endmodule

bind pe_binary_cell pe_binary_cell_chk #(.S(S)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .proc_en    (proc_en),
    .instr_word (instr_word),
    .nbr_n      (nbr_n),
    .nbr_out    (nbr_out),
    .bank_q     (bank_q)
);

// File: tb/pe_binary_cell_bench.sv
`timescale 1ns/100ps
module pe_binary_cell_bench;

    localparam int S = 3;
    localparam int N = 1 << S;
    localparam int W = 4 * S + 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         proc_en = 1'b0;
    logic [W-1:0] instr_word = '0;
    logic         nbr_n = 1'b0, nbr_e = 1'b0, nbr_w = 1'b0, nbr_s = 1'b0;
    logic         nbr_out;

    int     n_vec = 0;
    int     n_bad = 0;
    logic   done = 1'b0;
    logic [N-1:0]  model = '0;
    logic [15:0]   lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    pe_binary_cell #(.S(S)) u_pe_binary_cell (
        .clk(clk), .rst(rst), .proc_en(proc_en), .instr_word(instr_word),
        .nbr_n(nbr_n), .nbr_e(nbr_e), .nbr_w(nbr_w), .nbr_s(nbr_s),
        .nbr_out(nbr_out)
    );

    function automatic logic [W-1:0] pack(input int op, input int af, input int aa,
                                          input int bb, input int rr, input int oo);
        pack = {2'(op), 1'(af), 3'(aa), 3'(bb), 3'(rr), 3'(oo)};   // R2 layout
    endfunction

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // Sweep out_addr over every register and compare with the model (R9).
    task automatic check_bank(input string tag);
        for (int k = 0; k < N; k++) begin
            instr_word[S-1:0] = 3'(k);
            #0.2;
            n_vec++;
            if (nbr_out !== model[k]) begin
                n_bad++;
                $display("FAIL %s reg %0d: actual %b expected %b", tag, k, nbr_out, model[k]);
            end
        end
    endtask

    task automatic apply(input int op, input int af, input int aa, input int bb,
                         input int rr, input logic en, input string tag);
        logic [3:0] nb;
        logic a, b, r;
        @(negedge clk);
        step_lfsr();
        nb = lfsr[3:0];
        {nbr_s, nbr_w, nbr_e, nbr_n} = nb;   // index 0 N, 1 E, 2 W, 3 S (R4)
        proc_en    = en;
        instr_word = pack(op, af, aa, bb, rr, 0);
        a = af ? nb[aa[1:0]] : model[aa];     // R4, R8: old values
        b = model[bb];                        // R5
        case (op)                             // R3
            0: r = a;
            1: r = ~a;
            2: r = a & b;
            default: r = a | b;
        endcase
        @(posedge clk);
        #0.5;
        if (en) model[rr] = r;                // R6, R7
        check_bank(tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        check_bank("R1");
        // Load random neighbour data into every register.
        for (int i = 0; i < N; i++) apply(0, 1, i % 4, 0, i, 1'b1, "R4");
        // Enable held low: nothing may change.
        for (int i = 0; i < 64; i++) apply(i % 4, i % 2, i % 8, (i * 3) % 8, (i * 5) % 8, 1'b0, "R7");
        // Exhaustive field sweep.
        for (int op = 0; op < 4; op++)
            for (int af = 0; af < 2; af++)
                for (int aa = 0; aa < N; aa++)
                    for (int bb = 0; bb < N; bb++)
                        for (int rr = 0; rr < N; rr++) begin
                            if (lfsr[7:5] == 3'b000)
                                apply(op, af, aa, bb, rr, 1'b0, "R7");
                            else
                                apply(op, af, aa, bb, rr, 1'b1, "R3 R4 R5 R6 R8");
                        end
        // Reset in the middle of a run clears the bank again.
        @(negedge clk);
        rst = 1'b1;
        proc_en = 1'b1;
        @(posedge clk);
        #0.5;
        model = '0;
        check_bank("R1");
        @(negedge clk);
        rst = 1'b0;
        proc_en = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule